// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers interrupt requests from a small set of memory-mapped devices and turns them into a single interrupt line for the processor. Each device has a status word that holds two bits. One is a ready flag, driven by the device. The other is an enable flag, which software writes. Each device also has a fixed urgency level from 0 (least urgent) to 7 (most urgent). A device requests service only when both of its flags are set. Among the devices that are requesting, a priority encoder picks the most urgent one.

The winner's level is compared with the running program's level, which is taken from bits [10:8] of the processor status word. The interrupt is raised only when the winner is strictly more urgent than the running program. When the interrupt is raised, the winner's vector number and level are shown beside it. They stay frozen until the interrupt is dropped, so the processor reads a consistent pair while it takes the interrupt.

A single small register port lets software write each device's enable flag and read back both flags.

Top module: `irq_arbiter`

## Requirements
- R1: A device requests service only when its ready flag (status bit 15) and its enable flag (status bit 14) are both 1. Either flag alone produces no interrupt.
- R2: Device urgency levels are fixed by a parameter. The defaults are: device 0 and device 1 at level 4, device 2 at 1, device 3 at 6, device 4 at 2, device 5 at 6, device 6 at 3, and device 7 at 5. `irq_level` reports the level of the device that won.
- R3: Among the requesting devices, the highest level wins. When several devices share that level, the lowest device index wins.
- R4: `irq_out` rises only when the winner's level is strictly greater than `psr[10:8]`. An equal level does not raise it. A change in `psr` acts on `irq_out` at the next clock edge.
- R5: `irq_vector` equals VEC_BASE plus the winning device index. The default VEC_BASE is 0x40.
- R6: A read returns the ready flag in bit 15 and the enable flag in bit 14, with all other bits 0. `bus_rdata` is registered: it shows the device addressed by `bus_addr` one edge after the flags are sampled.
- R7: A write with `bus_we` high sets the enable flag of device `bus_addr` from `bus_wdata[14]`. Bit 15 of the written data is ignored, because the ready flag follows only `dev_ready`.
- R8: `dev_ready` is registered once, and the outputs are registered once more. A change in `dev_ready` therefore reaches `irq_out` on the second rising edge. An enable write reaches `irq_out` on the edge after the write edge.
- R9: While `irq_out` is high, `irq_vector` and `irq_level` hold their values, even if a more urgent request appears. `irq_out` falls when the held device stops requesting, or when `psr[10:8]` reaches or exceeds the held level. A fresh choice is made on the edge after it falls.
- R10: Synchronous reset clears all enable flags, `irq_out`, `irq_vector`, `irq_level` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Device index for reads and writes |
| bus_we | input | 1 | Write strobe for the enable flag |
| bus_wdata | input | 16 | Write data (bit 14 is used) |
| bus_rdata | output | 16 | Registered status read-back |
| dev_ready | input | 8 | Ready flag from each device |
| psr | input | 16 | Processor status word (running level in [10:8]) |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_vector | output | 8 | Vector number of the held winner |
| irq_level | output | 3 | Urgency level of the held winner |

## Verification
Two functions can fall in the same cycle while an interrupt is being held.

The first case is a more urgent device becoming ready while a less urgent one is held. The bench provokes this by raising device 3 while device 0 is held. It then expects the vector and level to stay at device 0's values until device 0 withdraws. After that it expects one low cycle, followed by device 3 winning.

The second case is the running level rising to meet the held level. The bench expects `irq_out` to drop on the very next edge.

Ties and the equal-level mask case are judged against the fixed default level table.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W    = 3;
  localparam int DATA_W   = 16;
  localparam int RDY_BIT  = 15;
  localparam int IE_BIT   = 14;
  localparam int PSR_LVL_LO = 8;

  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dev_status_regs.sv
module dev_status_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int IDX_W = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_ready,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   addr,
  input  logic               wr_ie,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_DEV-1:0] req
);
  logic [NUM_DEV-1:0] rdy_q;
  logic [NUM_DEV-1:0] ie_q;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    always_ff @(posedge clk) begin
      if (rst) begin
        rdy_q[g] <= 1'b0;
        ie_q[g]  <= 1'b0;
      end else begin
        rdy_q[g] <= dev_ready[g];
        if (wr_en && addr == IDX_W'(g)) ie_q[g] <= wr_ie;
      end
    end
    assign req[g] = rdy_q[g] & ie_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data          <= '0;
      rd_data[RDY_BIT] <= rdy_q[addr];
      rd_data[IE_BIT]  <= ie_q[addr];
    end
  end
endmodule

// File: rtl/prio_select.sv
module prio_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS = '0,
  localparam int IDX_W = $clog2(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0] req,
  output logic               hit,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (req[i] && (!hit || DEV_LEVELS[i*LVL_W +: LVL_W] >= win_lvl)) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = DEV_LEVELS[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_hold_stage.sv
module irq_hold_stage
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = '0,
  localparam int IDX_W = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  input  logic               hit,
  input  logic [IDX_W-1:0]   win_idx,
  input  lvl_t               win_lvl,
  input  lvl_t               cur_lvl,
  output logic               irq_out,
  output logic [VEC_W-1:0]   irq_vector,
  output lvl_t               irq_level
);
  logic [IDX_W-1:0] held_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out    <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
      held_idx   <= '0;
    end else if (irq_out) begin
      if (!(req[held_idx] && irq_level > cur_lvl)) irq_out <= 1'b0;
    end else if (hit && win_lvl > cur_lvl) begin
      irq_out    <= 1'b1;
      held_idx   <= win_idx;
      irq_level  <= win_lvl;
      irq_vector <= VEC_BASE + VEC_W'(win_idx);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
  parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS =
    {3'd5, 3'd3, 3'd6, 3'd2, 3'd6, 3'd1, 3'd4, 3'd4},
  localparam int IDX_W = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_DEV-1:0] dev_ready,
  input  logic [DATA_W-1:0]  psr,
  output logic               irq_out,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [LVL_W-1:0]   irq_level
);
  logic [NUM_DEV-1:0] req;
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_lvl;
  logic               unused_bits;

  assign cur_lvl     = psr[PSR_LVL_LO +: LVL_W];
  assign unused_bits = ^{bus_wdata, psr};

  dev_status_regs #(.NUM_DEV(NUM_DEV)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .dev_ready (dev_ready),
    .wr_en     (bus_we),
    .addr      (bus_addr),
    .wr_ie     (bus_wdata[IE_BIT]),
    .rd_data   (bus_rdata),
    .req       (req)
  );

  prio_select #(.NUM_DEV(NUM_DEV), .DEV_LEVELS(DEV_LEVELS)) sel_i (
    .req     (req),
    .hit     (hit),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_hold_stage #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) hold_i (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .hit        (hit),
    .win_idx    (win_idx),
    .win_lvl    (win_lvl),
    .cur_lvl    (cur_lvl),
    .irq_out    (irq_out),
    .irq_vector (irq_vector),
    .irq_level  (irq_level)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = '0,
  parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS = '0,
  localparam int IDX_W = $clog2(NUM_DEV)
) (
  input logic               clk,
  input logic               rst,
  input lvl_t               cur_lvl,
  input logic [NUM_DEV-1:0] req,
  input logic               irq_out,
  input logic [VEC_W-1:0]   irq_vector,
  input lvl_t               irq_level
);
  logic [NUM_DEV-1:0] req_d;
  logic [VEC_W-1:0]   vec_off;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk) begin
    if (rst) req_d <= '0;
    else     req_d <= req;
  end

  assign vec_off = irq_vector - VEC_BASE;
  assign idx     = vec_off[IDX_W-1:0];

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> req_d[idx]);  // R1
  AST_LEVEL_FROM_TABLE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> irq_level == DEV_LEVELS[idx*LVL_W +: LVL_W]);  // R2
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> irq_level > $past(cur_lvl));  // R4
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (irq_out && $past(irq_out)) |-> ($stable(irq_vector) && $stable(irq_level)));  // R9
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_DEV(NUM_DEV), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .DEV_LEVELS(DEV_LEVELS)
) chk_i (
  .clk(clk), .rst(rst), .cur_lvl(cur_lvl), .req(req),
  .irq_out(irq_out), .irq_vector(irq_vector), .irq_level(irq_level)
);

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  dev_ready = '0;
  logic [15:0] psr = '0;
  logic        irq_out;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_level;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_arbiter dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_ready(dev_ready),
    .psr(psr), .irq_out(irq_out), .irq_vector(irq_vector), .irq_level(irq_level)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0;
  endtask

  task automatic clear_all();
    dev_ready = '0; psr = '0;
    for (int i = 0; i < 8; i++) bus_write(3'(i), 16'h0000);
    tick(3);
  endtask

  task automatic enable_all();
    for (int i = 0; i < 8; i++) bus_write(3'(i), 16'h4000);
    tick(1);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(3);
    rst = 1'b0; tick(1);
    check("R10 irq_out after reset", irq_out, 0);
    check("R10 vector after reset", irq_vector, 0);
    check("R10 level after reset", irq_level, 0);
    check("R10 rdata after reset", bus_rdata, 0);
  endtask

  task automatic t_gating();
    clear_all();
    dev_ready = 8'h08; tick(3);
    check("R1 ready without enable", irq_out, 0);
    dev_ready = 8'h00; bus_write(3, 16'h4000); tick(2);
    check("R1 enable without ready", irq_out, 0);
    dev_ready = 8'h08; tick(2);
    check("R1 both flags raise irq", irq_out, 1);
    check("R5 vector of device 3", irq_vector, 8'h43);
    check("R2 level of device 3", irq_level, 6);
  endtask

  task automatic t_latency();
    clear_all();
    bus_write(7, 16'h4000); tick(2);
    dev_ready = 8'h80; tick(1);
    check("R8 irq not yet after one edge", irq_out, 0);
    tick(1);
    check("R8 irq after two edges", irq_out, 1);
    check("R5 vector of device 7", irq_vector, 8'h47);
    check("R2 level of device 7", irq_level, 5);
  endtask

  task automatic t_mask();
    clear_all(); enable_all();
    psr = 16'h0600; dev_ready = 8'h08; tick(3);
    check("R4 equal level masked", irq_out, 0);
    psr = 16'h0500; tick(1);
    check("R4 lower running level lets irq through", irq_out, 1);
    check("R4 level reported", irq_level, 6);
  endtask

  task automatic t_priority();
    clear_all(); enable_all();
    dev_ready = 8'h07; tick(2);
    check("R3 tie at level 4 to device 0", irq_vector, 8'h40);
    check("R3 winner level 4", irq_level, 4);
    dev_ready = 8'h00; tick(3);
    dev_ready = 8'h28; tick(2);
    check("R3 tie at level 6 to device 3", irq_vector, 8'h43);
    dev_ready = 8'h00; tick(3);
    dev_ready = 8'hF0; tick(2);
    check("R3 highest level among 4..7", irq_vector, 8'h45);
    check("R3 level of device 5", irq_level, 6);
  endtask

  task automatic t_hold();
    clear_all(); enable_all();
    dev_ready = 8'h01; tick(2);
    check("R9 device 0 held", irq_vector, 8'h40);
    dev_ready = 8'h09; tick(2);
    check("R9 irq kept", irq_out, 1);
    check("R9 vector kept despite higher request", irq_vector, 8'h40);
    check("R9 level kept", irq_level, 4);
    dev_ready = 8'h08; tick(2);
    check("R9 drop when held withdraws", irq_out, 0);
    tick(1);
    check("R9 re-arbitrated irq", irq_out, 1);
    check("R9 re-arbitrated vector", irq_vector, 8'h43);
    psr = 16'h0600; tick(1);
    check("R9 drop when running level reaches held level", irq_out, 0);
  endtask

  task automatic t_regs();
    clear_all();
    bus_write(2, 16'hFFFF); tick(1);
    check("R7 ready bit not writable", bus_rdata, 16'h4000);
    dev_ready = 8'h04; tick(2);
    check("R6 both flags read back", bus_rdata, 16'hC000);
    bus_write(2, 16'h8000); tick(1);
    check("R7 enable cleared by write", bus_rdata, 16'h8000);
    bus_addr = 3; tick(1);
    check("R6 other device reads zero", bus_rdata, 16'h0000);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_gating();
    t_latency();
    t_mask();
    t_priority();
    t_hold();
    t_regs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule